// File: doc/BRIEF.md
# Reset Interrupt Broadcast Dispatcher

When an external reset request arrives, this block sends one reset interrupt packet to each hardware thread that is enabled in a 64-bit steering mask. The request is active low. On the first clock after the request goes low, the block takes a snapshot of the mask. It then visits the set bits in ascending index order. For each set bit it presents a fixed-format packet on a 146-bit CPU-bound output and waits for a valid/ready handshake before moving on.

Each packet names its target. The upper three bits of the bit index select the core and the lower three bits select the thread. The thread number is written into two separate packet fields. When every enabled thread has been served, a done flag rises and stays high until the request is released. Releasing the request clears the packet count, so the block is ready for the next sequence.

Top module: `rst_intr_bcast`

## Requirements
- R1: The mask is captured only on the first rising clock edge at which `rst_req_n` is sampled low after having been sampled high. Changes on `steer_mask` after that edge do not affect the sequence. A request that is already low when `sys_rst` releases starts no sequence.
- R2: Packets are issued in strictly ascending bit index. Indices whose captured mask bit is clear get no packet.
- R3: The number of handshakes in one sequence, and the final value of `pkt_count`, equal the number of set bits in the captured mask (0 to 64).
- R4: For bit index i, packet bits 13:11 carry i[5:3] (core). Packet bits 136:134 and bits 10:8 both carry i[2:0] (thread).
- R5: A presented packet has bit 145 (valid) = 1, bits 144:141 = 4'b0111, bits 15:14 = 2'b01 and bits 5:0 = 6'b000011. Every other bit not named in R4 is 0. When no packet is presented, the whole output is 0.
- R6: After each handshake (bit 145 and `pkt_ready` both high at a clock edge), bit 145 is low for at least the following cycle.
- R7: While bit 145 is high and `pkt_ready` is low, the packet output holds its value on the next cycle.
- R8: With an all-zero captured mask, no packet is issued. `done` is low in the cycle right after the capture edge and high in the cycle after that.
- R9: `done` rises one cycle after the last handshake and stays high while `rst_req_n` is low. While `done` is high, no packet is presented. One edge after `rst_req_n` is sampled high in that state, `done` and `pkt_count` are both 0.
- R10: While `sys_rst` is high at a clock edge, the block returns to idle: the packet output, `done` and `pkt_count` are all 0 after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| sys_rst | input | 1 | Synchronous active-high reset |
| rst_req_n | input | 1 | Active-low reset request that starts a broadcast |
| steer_mask | input | 64 | Live per-thread enable mask; sampled when a sequence starts |
| pkt_ready | input | 1 | Receiver accepts the presented packet |
| pkt_data | output | 146 | Interrupt packet; bit 145 is the valid flag |
| pkt_count | output | 7 | Packets accepted in the current sequence |
| done | output | 1 | All enabled threads have been served |

## Verification
The embedded properties are checked on every cycle. They cover the stability of a stalled packet, the idle gap after each handshake, the fixed header and vector fields, the two copies of the thread number, the bound on the count, and the rule that done excludes a valid packet. Other behaviours can only be shown by the bench's scenarios, because they depend on the sequence as a whole or on what the mask held at capture time. These are the ascending order with skipped indices, the total packet count against the mask's population, the fact that later mask changes are ignored, and the exact done timing for an empty mask. The same holds for the cleanup on request release, the behaviour after a reset in mid-sequence, and the rule that a request held low through reset does not start a sequence.

// File: rtl/rst_intr_bcast.sv
module rst_intr_bcast #(
  parameter int CORE_W = 3,
  parameter int THR_W  = 3,
  parameter int NTHR   = 1 << (CORE_W + THR_W),
  parameter int CNT_W  = CORE_W + THR_W + 1,
  parameter int PKT_W  = 146
) (
  input  logic             clk,
  input  logic             sys_rst,
  input  logic             rst_req_n,
  input  logic [NTHR-1:0]  steer_mask,
  input  logic             pkt_ready,
  output logic [PKT_W-1:0] pkt_data,
  output logic [CNT_W-1:0] pkt_count,
  output logic             done
);
  localparam int IDX_W  = CORE_W + THR_W;
  localparam int B_VLD  = 145;
  localparam int B_TYPH = 144;
  localparam int B_TYPL = 141;
  localparam int B_TID0 = 134;
  localparam int B_SUBL = 14;
  localparam int B_CID  = 11;
  localparam int B_TID1 = 8;
  localparam logic [3:0] PKT_TYPE = 4'b0111;
  localparam logic [1:0] PKT_SUB  = 2'b01;
  localparam logic [5:0] PKT_VEC  = 6'b000011;

  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_SEND, S_DONE} st_t;

  st_t              st;
  logic             req_prev;
  logic [NTHR-1:0]  pend;
  logic [PKT_W-1:0] pkt_q;
  logic [CNT_W-1:0] cnt_q;
  logic [IDX_W-1:0] nxt_idx;
  logic             any_pend;

  function automatic logic [PKT_W-1:0] encode(input logic [IDX_W-1:0] ix);
    logic [PKT_W-1:0] p;
    p = '0;
    p[B_VLD] = 1'b1;
    p[B_TYPH:B_TYPL] = PKT_TYPE;
    p[B_TID0 +: THR_W] = ix[THR_W-1:0];
    p[B_SUBL +: 2] = PKT_SUB;
    p[B_CID +: CORE_W] = ix[IDX_W-1:THR_W];
    p[B_TID1 +: THR_W] = ix[THR_W-1:0];
    p[5:0] = PKT_VEC;
    return p;
  endfunction

  always_comb begin
    nxt_idx = '0;
    for (int k = NTHR - 1; k >= 0; k--)
      if (pend[k]) nxt_idx = IDX_W'(k);
  end

  assign any_pend  = |pend;
  assign pkt_data  = pkt_q;
  assign pkt_count = cnt_q;
  assign done      = (st == S_DONE);

  always_ff @(posedge clk) begin
    if (sys_rst) begin
      st       <= S_IDLE;
      req_prev <= 1'b0;
      pend     <= '0;
      pkt_q    <= '0;
      cnt_q    <= '0;
    end else begin
      req_prev <= rst_req_n;
      case (st)
        S_IDLE:
          if (req_prev && !rst_req_n) begin
            pend  <= steer_mask;
            cnt_q <= '0;
            st    <= S_ISSUE;
          end
        S_ISSUE:
          if (!any_pend) st <= S_DONE;
          else begin
            pkt_q <= encode(nxt_idx);
            st    <= S_SEND;
          end
        S_SEND:
          if (pkt_ready) begin
            pkt_q         <= '0;
            pend[nxt_idx] <= 1'b0;
            cnt_q         <= cnt_q + 1'b1;
            st            <= S_ISSUE;
          end
        S_DONE:
          if (rst_req_n) begin
            pend  <= '0;
            cnt_q <= '0;
            st    <= S_IDLE;
          end
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_hold_R7: assert property (@(posedge clk) disable iff (sys_rst)
    pkt_data[B_VLD] && !pkt_ready |=> pkt_data[B_VLD] && $stable(pkt_data));

  assert_gap_R6: assert property (@(posedge clk) disable iff (sys_rst)
    pkt_data[B_VLD] && pkt_ready |=> !pkt_data[B_VLD]);

  assert_tid_dup_R4: assert property (@(posedge clk) disable iff (sys_rst)
    pkt_data[B_VLD] |-> pkt_data[B_TID0 +: THR_W] == pkt_data[B_TID1 +: THR_W]);

  assert_hdr_R5: assert property (@(posedge clk) disable iff (sys_rst)
    pkt_data[B_VLD] |-> pkt_data[B_TYPH:B_TYPL] == PKT_TYPE &&
                        pkt_data[B_SUBL +: 2] == PKT_SUB && pkt_data[5:0] == PKT_VEC);

  assert_cnt_R3: assert property (@(posedge clk) disable iff (sys_rst)
    pkt_count <= CNT_W'(NTHR));

  assert_done_hold_R9: assert property (@(posedge clk) disable iff (sys_rst)
    done && !rst_req_n |=> done);

  assert_done_idle_R9: assert property (@(posedge clk) disable iff (sys_rst)
    done |-> !pkt_data[B_VLD]);
endmodule

// File: tb/tb_rst_intr_bcast.sv
module tb_rst_intr_bcast;
  localparam int NTHR  = 64;
  localparam int PKT_W = 146;
  localparam int NVEC  = 6;

  localparam logic [63:0] VMASK [NVEC] = '{
    64'h0000_0000_0000_0001, 64'h8000_0000_0000_0001, 64'hFFFF_FFFF_FFFF_FFFF,
    64'h0000_0000_0000_00A5, 64'h0123_4567_89AB_CDEF, 64'h8000_0000_0000_0000};
  localparam int VRDY [NVEC] = '{0, 3, 0, 2, 4, 5};

  logic             clk = 1'b0;
  logic             sys_rst = 1'b1;
  logic             rst_req_n = 1'b1;
  logic [63:0]      steer_mask = '0;
  logic             pkt_ready = 1'b0;
  logic [PKT_W-1:0] pkt_data;
  logic [6:0]       pkt_count;
  logic             done;

  int checks = 0;
  int fails = 0;
  int wd = 0;

  rst_intr_bcast dut (
    .clk(clk), .sys_rst(sys_rst), .rst_req_n(rst_req_n), .steer_mask(steer_mask),
    .pkt_ready(pkt_ready), .pkt_data(pkt_data), .pkt_count(pkt_count), .done(done));

  always #5 clk = ~clk;

  always @(posedge clk) begin
    wd++;
    if (wd > 100000) begin
      fails++;
      $display("FAIL watchdog: run hung, act=%0d exp<100000", wd);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [159:0] act, input logic [159:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [PKT_W-1:0] exp_pkt(input int i);
    logic [PKT_W-1:0] p = '0;
    logic [5:0] ix = 6'(i);
    p[145] = 1'b1;
    p[144:141] = 4'b0111;
    p[136:134] = ix[2:0];
    p[15:14] = 2'b01;
    p[13:11] = ix[5:3];
    p[10:8] = ix[2:0];
    p[5:0] = 6'b000011;
    return p;
  endfunction

  function automatic int next_set(input logic [63:0] m, input int from);
    for (int k = from; k < NTHR; k++)
      if (m[k]) return k;
    return NTHR;
  endfunction

  task automatic run_seq(input logic [63:0] mask, input int rp);
    int exp_idx = 0;
    int sent = 0;
    int cur = 0;
    bit just_hs = 0;
    bit held = 0;
    bit rdy;
    logic [PKT_W-1:0] last = '0;
    steer_mask = mask;
    rst_req_n = 1'b0;
    pkt_ready = 1'b0;
    @(negedge clk);
    steer_mask = ~mask;
    for (int cyc = 0; cyc < 800 && !done; cyc++) begin
      if (pkt_data[145]) begin
        cur = next_set(mask, exp_idx);
        chk(pkt_data == exp_pkt(cur), "R2 R4 R5 R1 packet", 160'(pkt_data), 160'(exp_pkt(cur)));
        if (held) chk(pkt_data == last, "R7 stall hold", 160'(pkt_data), 160'(last));
      end else begin
        chk(pkt_data == '0, "R5 idle output", 160'(pkt_data), 160'(0));
        if (just_hs) checks++;
      end
      just_hs = 0;
      rdy = (rp == 0) || (cyc % rp == rp - 1);
      pkt_ready = rdy;
      if (pkt_data[145] && rdy) begin
        sent++;
        exp_idx = cur + 1;
        just_hs = 1;
        held = 0;
      end else held = pkt_data[145];
      last = pkt_data;
      @(negedge clk);
      if (just_hs) chk(!pkt_data[145], "R6 gap after handshake", 160'(pkt_data[145]), 160'(0));
    end
    pkt_ready = 1'b0;
    chk(done, "R9 done reached", 160'(done), 160'(1));
    chk(sent == $countones(mask), "R3 handshake count", 160'(sent), 160'($countones(mask)));
    chk(pkt_count == 7'($countones(mask)), "R3 pkt_count", 160'(pkt_count), 160'($countones(mask)));
    chk(next_set(mask, exp_idx) == NTHR, "R2 no index left", 160'(next_set(mask, exp_idx)), 160'(NTHR));
    repeat (2) @(negedge clk);
    chk(done && !pkt_data[145], "R9 done held", 160'({done, pkt_data[145]}), 160'(2));
    rst_req_n = 1'b1;
    @(negedge clk);
    chk(!done && pkt_count == 0, "R9 release clears", 160'({done, pkt_count}), 160'(0));
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(pkt_data == '0 && !done && pkt_count == 0, "R10 reset state", 160'({pkt_data[145], done, pkt_count}), 160'(0));
    sys_rst = 1'b0;
    repeat (2) @(negedge clk);

    for (int v = 0; v < NVEC; v++) run_seq(VMASK[v], VRDY[v]);

    // R8: empty mask
    steer_mask = '0;
    rst_req_n = 1'b0;
    @(negedge clk);
    steer_mask = '1;
    chk(!done && !pkt_data[145], "R8 done not yet", 160'({done, pkt_data[145]}), 160'(0));
    @(negedge clk);
    chk(done && !pkt_data[145], "R8 done after empty capture", 160'({done, pkt_data[145]}), 160'(2));
    chk(pkt_count == 0, "R8 no packets", 160'(pkt_count), 160'(0));
    rst_req_n = 1'b1;
    repeat (2) @(negedge clk);

    // R10: reset in mid-sequence, request held low through reset (R1)
    steer_mask = '1;
    pkt_ready = 1'b1;
    rst_req_n = 1'b0;
    repeat (4) @(negedge clk);
    pkt_ready = 1'b0;
    @(negedge clk);
    chk(pkt_data[145] && pkt_count != 0, "R10 sequence underway", 160'({pkt_data[145], pkt_count}), 160'(1));
    sys_rst = 1'b1;
    @(negedge clk);
    chk(pkt_data == '0 && !done && pkt_count == 0, "R10 mid-sequence reset", 160'({pkt_data[145], done, pkt_count}), 160'(0));
    sys_rst = 1'b0;
    pkt_ready = 1'b1;
    for (int c = 0; c < 5; c++) begin
      @(negedge clk);
      chk(!pkt_data[145] && !done, "R1 held request starts nothing", 160'({pkt_data[145], done}), 160'(0));
    end
    rst_req_n = 1'b1;
    pkt_ready = 1'b0;
    repeat (2) @(negedge clk);
    run_seq(64'h0000_0000_0000_0040, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule